// File: doc/BRIEF.md
# Serial Audio Link Command Engine

This block is the host-facing part of a serial audio codec link controller. A host reaches five 32-bit registers over a simple select/write bus. The registers hold the link configuration, a status word, the enable controls, and a single command/response register. A write to the command register becomes one codec register transfer. The command is serialised into slots 1 and 2 of the next outgoing 256-bit frame, and the slot 0 tag marks those slots valid only in that frame. For a codec register read, the engine watches later incoming frames. It takes the reply from incoming slot 2 of the first frame whose tag marks slot 2 valid, and holds it for the host. If no reply arrives within a set number of frames, the engine gives up and returns all ones.

The same registers drive the codec reset line and the frame sync line directly. This lets software run a cold reset by holding the reset line, and a warm reset by forcing sync high. The block reports codec ready once the codec flags ready after reset is released. It also keeps sticky overflow and underflow flags that an external sample FIFO reports, and those flags clear only when the host writes ones to them. One system clock serves as the link bit clock, so one clock cycle carries one link bit.

Top module: `aclink_cmd_engine`

## Requirements
- R1: After reset, the enable register (0x10) reads 0x2 (bit 1 set = disabled, bit 0 clear = clock enable off), config (0x00) reads 0, status (0x04) reads 0 with the FIFO level inputs low, reset out is high and sync is low; config bits 22:0 read back as written.
- R2: While enabled (enable bit 0 set, bit 1 clear) and without sync override, a frame lasts 256 cycles, and sync is high for exactly the 16 cycles of slot 0.
- R3: An accepted command register (0x0C) write with bit 7 clear sends, in the next frame, tag bits 15:13 all set (frame positions 0 to 2), slot 1 = {0, index bits 6:0, 12 zero bits} and slot 2 = {write data bits 31:16, 4 zero bits}. Frames with no command carry a zero tag. Pending (status bit 6) clears after that frame.
- R4: A command with bit 7 set sends slot 1 with MSB 1 and slot 2 zero, and keeps pending set. The first later incoming frame with tag bit 13 (frame position 2) set provides incoming slot 2 bits 19:4, which then read in command register bits 15:0, and pending clears.
- R5: An incoming frame whose tag bit 13 is clear does not supply a read reply, whatever its slot 2 contents.
- R6: When no valid reply arrives in the 4 frames (REPLY_FRAMES) after the command frame, the response becomes 0xFFFF and pending clears.
- R7: A command write made while pending is set is ignored and never reaches the link.
- R8: The response stays unchanged until the next accepted command write, which clears it to 0.
- R9: Status bits 11 (tx underflow), 10 (tx overflow), 9 (rx underflow) and 8 (rx overflow) are set by a pulse on fifo_err_evt bits 3, 2, 1 and 0 respectively. They stay set until a status write has a 1 in that bit, and a 0 written there has no effect.
- R10: Status bits 4, 3, 1 and 0 show fifo_level bits 3 (tx empty), 2 (tx full), 1 (rx empty) and 0 (rx full).
- R11: Config bit 0 set drives link_rst_n low and clears codec ready (status bit 7). With it clear, codec ready sets once an incoming frame has frame position 0 high, and then stays set.
- R12: Config bits 2 and 1 both set hold sync high. Bit 2 alone holds sync low. Bit 2 clear gives normal framing.
- R13: While disabled, no sync or data leaves the block, and command writes are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after the access |
| fifo_err_evt | input | 4 | Error pulses: tx under, tx over, rx under, rx over |
| fifo_level | input | 4 | Levels: tx empty, tx full, rx empty, rx full |
| link_sync | output | 1 | Frame sync to the codec |
| link_sdout | output | 1 | Serial data to the codec |
| link_sdin | input | 1 | Serial data from the codec |
| link_rst_n | output | 1 | Codec reset, active low |

## Verification
The hardest case to reach is a read reply that lands frames after the command, because the codec's answer has to be placed at the right positions of a frame chosen by the bench. The bench locks onto the rising edge of sync and drives a full 256-bit incoming frame bit by bit, so it can send a frame with slot 2 marked invalid and then a valid one later. It then checks the reply, the timeout value, and how long pending stays set. The ignored second command is caught by checking that the frame after the command frame carries a zero tag.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int AW      = 5;
  localparam int CNT_W   = 8;
  localparam int SLOT_W  = 20;
  localparam int CFG_W   = 23;

  localparam logic [AW-1:0] A_CFG  = 5'h00;
  localparam logic [AW-1:0] A_STAT = 5'h04;
  localparam logic [AW-1:0] A_DATA = 5'h08;
  localparam logic [AW-1:0] A_CMD  = 5'h0C;
  localparam logic [AW-1:0] A_EN   = 5'h10;

  // frame positions (bit 0 of a frame is the tag MSB)
  localparam logic [CNT_W-1:0] P_FRAME_LAST = 8'd255;
  localparam logic [CNT_W-1:0] P_SLOT0_END  = 8'd16;
  localparam logic [CNT_W-1:0] P_TAG_LAST   = 8'd2;
  localparam logic [CNT_W-1:0] P_S2V        = 8'd2;
  localparam logic [CNT_W-1:0] P_S1_END     = 8'd36;
  localparam logic [CNT_W-1:0] P_S1_LAST    = 8'd35;
  localparam logic [CNT_W-1:0] P_S2_END     = 8'd56;
  localparam logic [CNT_W-1:0] P_S2_LAST    = 8'd55;
  localparam logic [CNT_W-1:0] P_READY      = 8'd0;
endpackage

// File: rtl/acl_regs.sv
module acl_regs
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic [3:0]        fifo_err_evt,
  input  logic [3:0]        fifo_level,
  input  logic              pend,
  input  logic              ready,
  input  logic [15:0]       resp,
  output logic              active,
  output logic              cfg_rst,
  output logic              cfg_gate,
  output logic              cfg_sctl,
  output logic              cmd_wr
);
  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       en_q;
  logic [3:0]       err_q;
  logic             wr_stb, rd_stb, stat_wr;
  logic [3:0]       err_clr;
  logic [31:0]      stat_w;

  assign wr_stb  = host_sel & host_wr;
  assign rd_stb  = host_sel & ~host_wr;
  assign stat_wr = wr_stb && (host_addr == A_STAT);
  assign err_clr = stat_wr ? host_wdata[11:8] : 4'b0;
  assign cmd_wr  = wr_stb && (host_addr == A_CMD);

  assign active   = en_q[0] & ~en_q[1];
  assign cfg_rst  = cfg_q[0];
  assign cfg_sctl = cfg_q[1];
  assign cfg_gate = cfg_q[2];

  assign stat_w = {20'b0, err_q, ready, pend, 1'b0, fifo_level[3:2], 1'b0, fifo_level[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      en_q       <= 2'b10;
      err_q      <= '0;
      host_rdata <= '0;
    end else begin
      if (wr_stb && host_addr == A_CFG) cfg_q <= host_wdata[CFG_W-1:0];
      if (wr_stb && host_addr == A_EN)  en_q  <= host_wdata[1:0];
      err_q <= (err_q & ~err_clr) | fifo_err_evt;
      if (rd_stb) begin
        unique case (host_addr)
          A_CFG:   host_rdata <= {{(32-CFG_W){1'b0}}, cfg_q};
          A_STAT:  host_rdata <= stat_w;
          A_CMD:   host_rdata <= {16'b0, resp};
          A_EN:    host_rdata <= {30'b0, en_q};
          default: host_rdata <= '0;
        endcase
      end
    end
  end

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_q & $past(err_q & ~err_clr)) == $past(err_q & ~err_clr)));
endmodule

// File: rtl/acl_frame.sv
module acl_frame
  import aclink_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             gate,
  input  logic             sctl,
  input  logic             want_send,
  input  logic             cmd_rd,
  input  logic [6:0]       cmd_idx,
  input  logic [15:0]      cmd_data,
  output logic             link_sync,
  output logic             link_sdout,
  output logic [CNT_W-1:0] pos_q,
  output logic             pos_vld,
  output logic             frame_end,
  output logic             send_q
);
  logic [CNT_W-1:0]  bit_cnt;
  logic              send_now, out_bit;
  logic [SLOT_W-1:0] s1, s2;
  logic [CNT_W-1:0]  off1, off2;

  assign send_now  = (bit_cnt == '0) ? want_send : send_q;
  assign frame_end = active && (bit_cnt == P_FRAME_LAST);
  assign s1   = {cmd_rd, cmd_idx, 12'b0};
  assign s2   = cmd_rd ? '0 : {cmd_data, 4'b0};
  assign off1 = P_S1_LAST - bit_cnt;
  assign off2 = P_S2_LAST - bit_cnt;

  always_comb begin
    if (bit_cnt < P_SLOT0_END)   out_bit = send_now && (bit_cnt <= P_TAG_LAST);
    else if (bit_cnt < P_S1_END) out_bit = send_now && s1[off1[4:0]];
    else if (bit_cnt < P_S2_END) out_bit = send_now && s2[off2[4:0]];
    else                         out_bit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      send_q     <= 1'b0;
      link_sync  <= 1'b0;
      link_sdout <= 1'b0;
      pos_q      <= '0;
      pos_vld    <= 1'b0;
    end else begin
      bit_cnt    <= active ? bit_cnt + 1'b1 : '0;
      send_q     <= active & send_now;
      link_sdout <= active & out_bit;
      link_sync  <= active & (gate ? sctl : (bit_cnt < P_SLOT0_END));
      pos_q      <= bit_cnt;
      pos_vld    <= active;
    end
  end

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!link_sync && !link_sdout));
  p_sync_forced_r12: assert property (@(posedge clk) disable iff (rst)
    (active && gate && sctl) |=> link_sync);
endmodule

// File: rtl/acl_cmd.sv
module acl_cmd
  import aclink_pkg::*;
#(
  parameter int REPLY_FRAMES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             cmd_wr,
  input  logic [31:0]      wdata,
  input  logic             frame_end,
  input  logic             send_q,
  input  logic [CNT_W-1:0] pos_q,
  input  logic             pos_vld,
  input  logic             sdin,
  input  logic             cfg_rst,
  output logic             pend,
  output logic             want_send,
  output logic             cmd_rd,
  output logic [6:0]       cmd_idx,
  output logic [15:0]      cmd_data,
  output logic [15:0]      resp,
  output logic             ready
);
  localparam int WC_W = (REPLY_FRAMES > 1) ? $clog2(REPLY_FRAMES) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(REPLY_FRAMES - 1);

  logic              sent, s2v, accept;
  logic [WC_W-1:0]   wait_cnt;
  logic [SLOT_W-1:0] sr;

  assign accept    = cmd_wr && !pend && active;
  assign want_send = pend && !sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; sent <= 1'b0; s2v <= 1'b0; wait_cnt <= '0; sr <= '0;
      cmd_rd <= 1'b0; cmd_idx <= '0; cmd_data <= '0; resp <= '0; ready <= 1'b0;
    end else begin
      sr <= {sr[SLOT_W-2:0], sdin};
      if (pos_vld && pos_q == P_S2V) s2v <= sdin;
      if (cfg_rst) ready <= 1'b0;
      else if (pos_vld && pos_q == P_READY && sdin) ready <= 1'b1;

      if (!active) begin
        pend <= 1'b0;
        sent <= 1'b0;
      end else if (accept) begin
        pend     <= 1'b1;
        sent     <= 1'b0;
        cmd_rd   <= wdata[7];
        cmd_idx  <= wdata[6:0];
        cmd_data <= wdata[31:16];
        resp     <= '0;
      end else if (frame_end && send_q) begin
        if (cmd_rd) begin
          sent     <= 1'b1;
          wait_cnt <= '0;
        end else pend <= 1'b0;
      end else if (sent && pos_vld && pos_q == P_S2_LAST && s2v) begin
        resp <= sr[SLOT_W-2:3];
        pend <= 1'b0;
        sent <= 1'b0;
      end else if (sent && frame_end) begin
        if (wait_cnt == WC_LAST) begin
          resp <= 16'hFFFF;
          pend <= 1'b0;
          sent <= 1'b0;
        end else wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  p_resp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!pend && !cmd_wr) |=> $stable(resp));
  p_ready_clear_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_rst |=> !ready);
  p_pend_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(cmd_wr));
endmodule

// File: rtl/aclink_cmd_engine.sv
module aclink_cmd_engine
  import aclink_pkg::*;
#(
  parameter int REPLY_FRAMES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [4:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic [3:0]    fifo_err_evt,
  input  logic [3:0]    fifo_level,
  output logic          link_sync,
  output logic          link_sdout,
  input  logic          link_sdin,
  output logic          link_rst_n
);
  logic             active, cfg_rst, cfg_gate, cfg_sctl, cmd_wr;
  logic             pend, ready, want_send, cmd_rd, frame_end, send_q, pos_vld;
  logic [6:0]       cmd_idx;
  logic [15:0]      cmd_data, resp;
  logic [CNT_W-1:0] pos_q;

  assign link_rst_n = ~cfg_rst;

  acl_regs i_regs (
    .clk, .rst, .host_sel, .host_wr, .host_addr, .host_wdata, .host_rdata,
    .fifo_err_evt, .fifo_level, .pend, .ready, .resp,
    .active, .cfg_rst, .cfg_gate, .cfg_sctl, .cmd_wr
  );

  acl_frame i_frame (
    .clk, .rst, .active, .gate(cfg_gate), .sctl(cfg_sctl), .want_send,
    .cmd_rd, .cmd_idx, .cmd_data, .link_sync, .link_sdout,
    .pos_q, .pos_vld, .frame_end, .send_q
  );

  acl_cmd #(.REPLY_FRAMES(REPLY_FRAMES)) i_cmd (
    .clk, .rst, .active, .cmd_wr, .wdata(host_wdata), .frame_end, .send_q,
    .pos_q, .pos_vld, .sdin(link_sdin), .cfg_rst, .pend, .want_send,
    .cmd_rd, .cmd_idx, .cmd_data, .resp, .ready
  );
endmodule

// File: tb/test_aclink_cmd_engine.sv
`timescale 1ns/1ps
module test_aclink_cmd_engine;
  logic        clk = 0, rst = 1;
  logic        host_sel = 0, host_wr = 0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [3:0]  fifo_err_evt = '0, fifo_level = '0;
  logic        link_sync, link_sdout, link_sdin = 0, link_rst_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aclink_cmd_engine i_aclink_cmd_engine (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); host_sel = 1; host_wr = 0; host_addr = a;
    @(negedge clk); host_sel = 0; d = host_rdata;
  endtask

  function automatic logic [255:0] mk_in(input logic rdy, input logic s2v, input logic [15:0] d);
    logic [255:0] v = '0;
    v[255] = rdy; v[253] = s2v; v[219:204] = d;
    return v;
  endfunction

  task automatic grab(input logic aligned, input logic [255:0] din,
                      output logic [255:0] dout, output int hi);
    logic p;
    hi = 0;
    if (!aligned) begin
      p = link_sync;
      forever begin
        @(negedge clk);
        if (link_sync && !p) break;
        p = link_sync;
      end
    end
    for (int k = 0; k < 256; k++) begin
      dout[255-k] = link_sdout;
      if (link_sync) hi++;
      link_sdin = din[255-k];
      @(negedge clk);
    end
    link_sdin = 0;
  endtask

  task automatic quiet(input int n, input string req, input logic lvl);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (link_sync !== lvl) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(5'h10, d); chk("R1 enable", d, 32'h2);
    rd(5'h00, d); chk("R1 config", d, 0);
    rd(5'h04, d); chk("R1 status", d, 0);
    chk("R1 rst_n", link_rst_n, 1);
    chk("R1 sync", link_sync, 0);
    wr(5'h00, 32'h0000_6018);
    rd(5'h00, d); chk("R1 config readback", d, 32'h6018);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    quiet(600, "R13 no sync while disabled", 0);
    wr(5'h0C, 32'h0000_0002);
    rd(5'h04, d); chk("R13 cmd not accepted", d[6], 0);
    wr(5'h10, 32'h3);
    quiet(300, "R13 disable bit wins", 0);
    wr(5'h10, 32'h1);
    rd(5'h10, d); chk("R13 enable readback", d, 1);
  endtask

  task automatic t_frame;
    logic [255:0] o; int hi;
    grab(0, '0, o, hi);
    chk("R2 sync length", hi, 16);
    chk("R3 idle tag zero", o[255:240], 0);
    chk("R2 frame length", link_sync, 1);
  endtask

  task automatic t_write;
    logic [255:0] o; int hi; logic [31:0] d;
    wr(5'h0C, 32'h5A5A_0002);
    wr(5'h0C, 32'h1111_0033);
    grab(0, '0, o, hi);
    chk("R3 tag", o[255:240], 32'hE000);
    chk("R3 slot1", o[239:220], 32'h02000);
    chk("R3 slot2", o[219:200], 32'h5A5A0);
    chk("R7 first index kept", o[238:232], 32'h02);
    grab(1, '0, o, hi);
    chk("R7 ignored write not sent", o[255:240], 0);
    rd(5'h04, d); chk("R3 pending cleared", d[6], 0);
  endtask

  task automatic t_read;
    logic [255:0] o; int hi; logic [31:0] d;
    wr(5'h0C, 32'h0000_00A6);
    grab(0, '0, o, hi);
    chk("R4 tag", o[255:240], 32'hE000);
    chk("R4 slot1", o[239:220], 32'hA6000);
    chk("R4 slot2 zero", o[219:200], 0);
    grab(1, '0, o, hi);
    rd(5'h04, d); chk("R4 pending while waiting", d[6], 1);
    chk("R11 not ready yet", d[7], 0);
    grab(0, mk_in(1, 1, 16'h1234), o, hi);
    rd(5'h0C, d); chk("R4 reply", d, 32'h1234);
    rd(5'h04, d); chk("R4 pending cleared", d[6], 0);
    chk("R11 ready set", d[7], 1);
    repeat (600) @(negedge clk);
    rd(5'h0C, d); chk("R8 reply held", d, 32'h1234);
    wr(5'h0C, 32'h0000_0011);
    rd(5'h0C, d); chk("R8 cleared by new command", d, 0);
    grab(0, '0, o, hi);
  endtask

  task automatic t_timeout;
    logic [255:0] o; int hi; logic [31:0] d;
    wr(5'h0C, 32'h0000_0090);
    grab(0, '0, o, hi);
    for (int f = 0; f < 3; f++) grab(1, mk_in(1, 0, 16'hBEEF), o, hi);
    rd(5'h04, d); chk("R6 still pending within window", d[6], 1);
    for (int f = 0; f < 2; f++) grab(0, mk_in(1, 0, 16'hBEEF), o, hi);
    rd(5'h0C, d); chk("R5 R6 timeout value", d, 32'hFFFF);
    rd(5'h04, d); chk("R6 pending cleared", d[6], 0);
  endtask

  task automatic t_err;
    logic [31:0] d;
    fifo_level = 4'b1010;
    @(negedge clk); fifo_err_evt = 4'b1010;
    @(negedge clk); fifo_err_evt = 4'b0000;
    rd(5'h04, d); chk("R9 R10 flags set", d & 32'hF1B, 32'hA12);
    repeat (50) @(negedge clk);
    rd(5'h04, d); chk("R9 flags sticky", d & 32'hF1B, 32'hA12);
    wr(5'h04, 32'h800);
    rd(5'h04, d); chk("R9 w1c", d & 32'hF1B, 32'h212);
    wr(5'h04, 32'h0);
    rd(5'h04, d); chk("R9 zero write no effect", d & 32'hF1B, 32'h212);
    fifo_level = 4'b0101;
    rd(5'h04, d); chk("R10 levels", d & 32'hF1B, 32'h209);
  endtask

  task automatic t_cold;
    logic [255:0] o; int hi; logic [31:0] d;
    wr(5'h00, 32'h1);
    chk("R11 reset asserted", link_rst_n, 0);
    rd(5'h04, d); chk("R11 ready cleared", d[7], 0);
    wr(5'h00, 32'h0);
    chk("R11 reset released", link_rst_n, 1);
    rd(5'h04, d); chk("R11 ready waits for codec", d[7], 0);
    grab(0, mk_in(1, 0, 0), o, hi);
    rd(5'h04, d); chk("R11 ready after codec flag", d[7], 1);
  endtask

  task automatic t_warm;
    logic [255:0] o; int hi;
    wr(5'h00, 32'h6);
    quiet(300, "R12 sync forced high", 1);
    wr(5'h00, 32'h4);
    quiet(300, "R12 sync held low", 0);
    wr(5'h00, 32'h0);
    grab(0, '0, o, hi);
    chk("R12 normal framing back", hi, 16);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    t_reset;
    t_disabled;
    t_frame;
    t_write;
    t_read;
    t_timeout;
    t_err;
    t_cold;
    t_warm;
    wr(5'h10, 32'h2);
    quiet(300, "R13 disabled again", 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule